// File: doc/BRIEF.md
# Halt and Wake-up Sequencer

This block manages a small processor's low-power halt state. A halt command moves it from running to halted. While halted, it drops the system clock enable and watches four wake sources: an external reset request, an interrupt request, a falling edge on any port pin whose wake-enable bit is set, and a watchdog overflow. Once a wake is taken, the clock enable comes back. The core stays stalled for a fixed settling window. After that window the block issues one action pulse: resume at the next instruction, take the interrupt, perform a warm reset, or perform a full initialisation.

The block also holds the power-down and time-out status flags. From those two flags it decodes a one-hot reset-cause word that software reads after a restart. The wake clock that runs the block never stops, and port pins are sampled on it through a two-stage synchroniser.

Top module: `halt_wake_seq`

## Requirements
- R1: After reset: `clk_en`=1, `core_stall`=0, `halted`=0, `pdf`=0, `to_flag`=0, `cause`=4'b0001, and no action pulse.
- R2: A `halt_cmd` accepted in run state gives, one cycle later, `halted`=1, `clk_en`=0, `core_stall`=1, `pdf`=1 and `to_flag`=0.
- R3: `wdt_clr` in run state, without a halt taken in the same cycle, clears `pdf`.
- R4: While halted, a high-to-low transition on `port_in[i]` with `port_wake_en[i]`=1 wakes the block. A fall on a pin whose enable bit is 0 leaves it halted.
- R5: After every wake, exactly SETTLE_CYCLES (default 1024) cycles have `clk_en`=1 and `core_stall`=1. The action pulse then appears together with `core_stall` returning to 0.
- R6: An interrupt wake ends with `irq_take` when `irq_en`=1 and `stack_full`=0. It ends with `resume_next` otherwise. A port wake ends with `resume_next`.
- R7: If `irq_req` is already high when halt is entered, it cannot wake the block during that halt.
- R8: A watchdog overflow while halted wakes the block and sets `to_flag`. After settling it pulses `warm_reset` and not `full_init`, and `cause` becomes 4'b1000.
- R9: `ext_reset` while halted wakes the block and leaves both flags unchanged. After settling it pulses `full_init`.
- R10: A watchdog overflow in run state sets `to_flag` and pulses `full_init` in the next cycle. It wins over a `halt_cmd` in the same cycle, which is then not taken and leaves `pdf` unchanged.
- R11: Wake priority in one cycle is ext_reset over watchdog over interrupt over port. A watchdog overflow that loses to ext_reset does not set `to_flag`.
- R12: `cause` is one-hot and is indexed by {to_flag,pdf}: bit0 = 00, bit1 = 01 (reset during halt), bit2 = 10 (watchdog in run), bit3 = 11 (watchdog wake from halt).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running wake clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| halt_cmd | input | 1 | Halt command from the core |
| wdt_clr | input | 1 | Watchdog clear command from the core |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| ext_reset | input | 1 | External reset request, synchronous |
| irq_req | input | 1 | Interrupt request level |
| irq_en | input | 1 | Interrupt enabled |
| stack_full | input | 1 | Return stack has no free entry |
| port_in | input | PORT_W | Port pin levels |
| port_wake_en | input | PORT_W | Per-pin wake enable |
| clk_en | output | 1 | System clock enable |
| core_stall | output | 1 | Core must not execute |
| halted | output | 1 | Block is in the halt state |
| resume_next | output | 1 | Pulse: continue at next instruction |
| irq_take | output | 1 | Pulse: run the interrupt response |
| warm_reset | output | 1 | Pulse: reset program counter and stack pointer only |
| full_init | output | 1 | Pulse: full chip initialisation |
| pdf | output | 1 | Power-down flag |
| to_flag | output | 1 | Watchdog time-out flag |
| cause | output | 4 | One-hot reset cause decoded from the flags |

## Verification
Two collisions are forced on purpose. In the halted state the bench raises a watchdog overflow and an unblocked interrupt request on the same edge. The outcome must be a warm reset with `to_flag` set and no interrupt dispatch. In a second halt, ext_reset meets a watchdog overflow on the same edge: the result must be `full_init` with `to_flag` still clear. In run state, a watchdog overflow and a halt command arrive on the same edge. The bench requires that `halted` stays low, that `full_init` pulses once and that `pdf` keeps its previous value.

// File: rtl/hw_pkg.sv
package hw_pkg;

  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_SETTLE} hw_state_e;
  typedef enum logic [1:0] {WK_PORT, WK_IRQ, WK_WDT, WK_EXT} wake_src_e;

  // one-hot reset cause indexed by {to, pdf}
  function automatic logic [3:0] cause_onehot(input logic pdf, input logic to);
    logic [1:0] idx;
    idx = {to, pdf};
    return 4'b0001 << idx;
  endfunction

  // interrupt dispatch when enabled and there is room to push the return address
  function automatic logic take_irq(input logic en, input logic full);
    return en & ~full;
  endfunction

  // fixed wake priority: ext > wdt > irq > port
  function automatic wake_src_e pick_wake(input logic ext, input logic wdt, input logic irq);
    if (ext) return WK_EXT;
    if (wdt) return WK_WDT;
    if (irq) return WK_IRQ;
    return WK_PORT;
  endfunction

endpackage

// File: rtl/hw_port_edge.sv
module hw_port_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] en,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic s1, s2, prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1   <= 1'b1;
        s2   <= 1'b1;
        prev <= 1'b1;
      end else begin
        s1   <= pins[i];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign fall[i] = en[i] & prev & ~s2;
  end
endmodule

// File: rtl/hw_settle_timer.sv
module hw_settle_timer #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign last = busy && (cnt == LAST_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hw_status_flags.sv
module hw_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pdf,
  input  logic clr_pdf,
  input  logic set_to,
  input  logic clr_to,
  output logic pdf,
  output logic to
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdf <= 1'b0;
      to  <= 1'b0;
    end else begin
      if (set_pdf)      pdf <= 1'b1;
      else if (clr_pdf) pdf <= 1'b0;
      if (set_to)       to  <= 1'b1;
      else if (clr_to)  to  <= 1'b0;
    end
  end
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq #(
  parameter int PORT_W        = 8,
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_cmd,
  input  logic              wdt_clr,
  input  logic              wdt_ovf,
  input  logic              ext_reset,
  input  logic              irq_req,
  input  logic              irq_en,
  input  logic              stack_full,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] port_wake_en,
  output logic              clk_en,
  output logic              core_stall,
  output logic              halted,
  output logic              resume_next,
  output logic              irq_take,
  output logic              warm_reset,
  output logic              full_init,
  output logic              pdf,
  output logic              to_flag,
  output logic [3:0]        cause
);
  import hw_pkg::*;

  hw_state_e   state;
  wake_src_e   wake_kind;
  logic        irq_blk;
  logic [PORT_W-1:0] port_fall;

  // named internal events
  logic in_run, in_halt, in_settle;
  logic port_fall_any, irq_wake, wake_any, halt_take;
  logic set_to_w, clr_pdf_w, settle_last;
  logic q_resume, q_irq, q_warm, q_init;

  hw_port_edge #(.W(PORT_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .pins(port_in), .en(port_wake_en), .fall(port_fall)
  );

  assign in_run        = (state == ST_RUN);
  assign in_halt       = (state == ST_HALT);
  assign in_settle     = (state == ST_SETTLE);
  assign port_fall_any = |port_fall;
  assign irq_wake      = irq_req & ~irq_blk;
  assign wake_any      = in_halt & (ext_reset | wdt_ovf | irq_wake | port_fall_any);
  assign halt_take     = in_run & halt_cmd & ~wdt_ovf & ~ext_reset;
  assign set_to_w      = wdt_ovf & ~ext_reset & (in_run | in_halt);
  assign clr_pdf_w     = in_run & wdt_clr & ~halt_take;

  hw_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(wake_any), .busy(), .last(settle_last)
  );

  hw_status_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_pdf(halt_take), .clr_pdf(clr_pdf_w),
    .set_to(set_to_w), .clr_to(halt_take),
    .pdf(pdf), .to(to_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      wake_kind <= WK_PORT;
      irq_blk   <= 1'b0;
      q_resume  <= 1'b0;
      q_irq     <= 1'b0;
      q_warm    <= 1'b0;
      q_init    <= 1'b0;
    end else begin
      q_resume <= 1'b0;
      q_irq    <= 1'b0;
      q_warm   <= 1'b0;
      q_init   <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (ext_reset || wdt_ovf) begin
            q_init <= 1'b1;
          end else if (halt_take) begin
            state   <= ST_HALT;
            irq_blk <= irq_req;
          end
        end
        ST_HALT: begin
          if (wake_any) begin
            state     <= ST_SETTLE;
            wake_kind <= pick_wake(ext_reset, wdt_ovf, irq_wake);
          end
        end
        ST_SETTLE: begin
          if (settle_last) begin
            state   <= ST_RUN;
            irq_blk <= 1'b0;
            unique case (wake_kind)
              WK_EXT:  q_init <= 1'b1;
              WK_WDT:  q_warm <= 1'b1;
              WK_IRQ:  begin
                if (take_irq(irq_en, stack_full)) q_irq <= 1'b1;
                else                              q_resume <= 1'b1;
              end
              default: q_resume <= 1'b1;
            endcase
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign clk_en      = ~in_halt;
  assign core_stall  = ~in_run;
  assign halted      = in_halt;
  assign resume_next = q_resume;
  assign irq_take    = q_irq;
  assign warm_reset  = q_warm;
  assign full_init   = q_init;
  assign cause       = cause_onehot(pdf, to_flag);
endmodule

// File: rtl/hw_seq_checker.sv
module hw_seq_checker #(
  parameter int SETTLE_CYCLES = 1024
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_en,
  input logic       core_stall,
  input logic       halted,
  input logic       resume_next,
  input logic       irq_take,
  input logic       warm_reset,
  input logic       full_init,
  input logic       pdf,
  input logic       to_flag,
  input logic [3:0] cause,
  input logic       irq_blk,
  input logic       irq_req,
  input logic       ext_reset,
  input logic       wdt_ovf,
  input logic       port_fall_any
);
  localparam int SW = $clog2(SETTLE_CYCLES + 2);
  logic [SW-1:0] settle_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    settle_seen <= '0;
    else if (clk_en && core_stall) settle_seen <= settle_seen + 1'b1;
    else if (!core_stall)          settle_seen <= '0;
  end

  assert_cause_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cause) == 1);

  assert_gated_when_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (halted && core_stall));

  assert_halt_entry_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (pdf && !to_flag));

  assert_one_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_next, irq_take, warm_reset, full_init}));

  assert_settle_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_stall) |-> (settle_seen == SW'(SETTLE_CYCLES)));

  assert_irq_after_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(core_stall));

  assert_blocked_irq_no_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && irq_blk && irq_req && !ext_reset && !wdt_ovf && !port_fall_any) |=> halted);

  assert_warm_sets_to_R8: assert property (@(posedge clk) disable iff (!rst_n)
    warm_reset |-> to_flag);
endmodule

bind halt_wake_seq hw_seq_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .core_stall(core_stall),
  .halted(halted), .resume_next(resume_next), .irq_take(irq_take),
  .warm_reset(warm_reset), .full_init(full_init), .pdf(pdf), .to_flag(to_flag),
  .cause(cause), .irq_blk(irq_blk), .irq_req(irq_req), .ext_reset(ext_reset),
  .wdt_ovf(wdt_ovf), .port_fall_any(port_fall_any)
);

// File: tb/halt_wake_seq_tb.sv
module halt_wake_seq_tb;
  localparam int PW = 8;
  localparam int SETTLE = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_cmd = 0, wdt_clr = 0, wdt_ovf = 0, ext_reset = 0;
  logic irq_req = 0, irq_en = 0, stack_full = 0;
  logic [PW-1:0] port_in = '1, port_wake_en = '0;
  logic clk_en, core_stall, halted, resume_next, irq_take, warm_reset, full_init;
  logic pdf, to_flag;
  logic [3:0] cause;

  int total = 0, bad = 0;
  int n_settle, n_res, n_irq, n_warm, n_init;

  always #10 clk = ~clk;

  halt_wake_seq #(.PORT_W(PW), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .wdt_clr(wdt_clr),
    .wdt_ovf(wdt_ovf), .ext_reset(ext_reset), .irq_req(irq_req), .irq_en(irq_en),
    .stack_full(stack_full), .port_in(port_in), .port_wake_en(port_wake_en),
    .clk_en(clk_en), .core_stall(core_stall), .halted(halted),
    .resume_next(resume_next), .irq_take(irq_take), .warm_reset(warm_reset),
    .full_init(full_init), .pdf(pdf), .to_flag(to_flag), .cause(cause)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stimulus is already applied; one-shot inputs drop after the first edge
  task automatic watch_wake();
    n_settle = 0; n_res = 0; n_irq = 0; n_warm = 0; n_init = 0;
    for (int i = 0; i < 3000; i++) begin
      tick();
      wdt_ovf = 0; ext_reset = 0;
      if (clk_en && core_stall) n_settle++;
      n_res += int'(resume_next); n_irq += int'(irq_take);
      n_warm += int'(warm_reset); n_init += int'(full_init);
      if (!core_stall) break;
    end
  endtask

  task automatic enter_halt(input string req);
    halt_cmd = 1; tick(); halt_cmd = 0;
    chk(halted && !clk_en && core_stall, req, int'(halted), 1);
    chk(pdf && !to_flag, req, int'({to_flag, pdf}), 1);
  endtask

  task automatic t_reset();
    chk(clk_en && !core_stall && !halted, "R1", int'({clk_en, core_stall, halted}), 4);
    chk(!pdf && !to_flag && cause == 4'b0001, "R1", int'(cause), 1);
    chk({resume_next, irq_take, warm_reset, full_init} == 0, "R1",
        int'({resume_next, irq_take, warm_reset, full_init}), 0);
  endtask

  task automatic t_port_wake();
    port_wake_en = 8'b0000_0100;
    enter_halt("R2");
    port_in[2] = 0;
    watch_wake();
    port_in[2] = 1;
    chk(n_settle == SETTLE, "R5", n_settle, SETTLE);
    chk(n_res == 1 && n_irq == 0, "R4", n_res, 1);
    chk(cause == 4'b0010, "R12", int'(cause), 2);
  endtask

  task automatic t_wdt_clr();
    tick(); tick(); tick();
    wdt_clr = 1; tick(); wdt_clr = 0;
    chk(!pdf, "R3", int'(pdf), 0);
  endtask

  task automatic t_disabled_pin_then_irq();
    port_wake_en = 8'b0000_0100;
    enter_halt("R2");
    port_in[0] = 0;
    repeat (10) tick();
    chk(halted, "R4", int'(halted), 1);
    port_in[0] = 1;
    irq_en = 1; stack_full = 0; irq_req = 1;
    watch_wake();
    irq_req = 0;
    chk(n_irq == 1 && n_res == 0, "R6", n_irq, 1);
  endtask

  task automatic t_irq_stack_full();
    enter_halt("R2");
    irq_en = 1; stack_full = 1; irq_req = 1;
    watch_wake();
    irq_req = 0; stack_full = 0;
    chk(n_res == 1 && n_irq == 0, "R6", n_res, 1);
  endtask

  task automatic t_irq_pending();
    irq_en = 1; irq_req = 1;
    repeat (4) tick();
    enter_halt("R2");
    repeat (10) tick();
    chk(halted, "R7", int'(halted), 1);
    port_in[2] = 0;
    watch_wake();
    port_in[2] = 1; irq_req = 0;
    chk(n_res == 1 && n_irq == 0, "R7", n_res, 1);
    repeat (4) tick();
  endtask

  task automatic t_wdt_halt();
    enter_halt("R2");
    wdt_ovf = 1;
    watch_wake();
    chk(n_warm == 1 && n_init == 0, "R8", n_warm, 1);
    chk(to_flag && pdf && cause == 4'b1000, "R8", int'(cause), 8);
  endtask

  task automatic t_ext_halt();
    enter_halt("R2");
    ext_reset = 1;
    watch_wake();
    chk(n_init == 1 && n_warm == 0, "R9", n_init, 1);
    chk(pdf && !to_flag && cause == 4'b0010, "R9", int'(cause), 2);
  endtask

  task automatic t_priority();
    irq_en = 1; stack_full = 0;
    enter_halt("R2");
    wdt_ovf = 1; irq_req = 1;
    watch_wake();
    irq_req = 0;
    chk(n_warm == 1 && n_irq == 0, "R11", n_warm, 1);
    enter_halt("R2");
    wdt_ovf = 1; ext_reset = 1;
    watch_wake();
    chk(n_init == 1 && !to_flag, "R11", int'(to_flag), 0);
  endtask

  task automatic t_wdt_run();
    wdt_clr = 1; tick(); wdt_clr = 0;
    halt_cmd = 1; wdt_ovf = 1; tick(); halt_cmd = 0; wdt_ovf = 0;
    chk(!halted && full_init, "R10", int'({halted, full_init}), 1);
    chk(to_flag && !pdf && cause == 4'b0100, "R12", int'(cause), 4);
    tick();
    chk(!full_init, "R10", int'(full_init), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    tick();
    t_reset();
    t_port_wake();
    t_wdt_clr();
    t_disabled_pin_then_irq();
    t_irq_stack_full();
    t_irq_pending();
    t_wdt_halt();
    t_ext_halt();
    t_priority();
    t_wdt_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule